// File: doc/BRIEF.md
# Emergency Output Disable Controller

This block turns a set of fault indications into output-enable signals for two groups of timer output pins. One group holds six complementary PWM pins, arranged as three high/low pairs. The other group holds three pins of a single timer channel. When a qualifying fault is seen, the block drives the affected group's output enables low, and the pin drivers place those pins in high-impedance.

There are five fault sources:

- a level of any input-detection flag;
- a short-through comparator that watches the complementary pin pairs;
- an oscillation-stop indication;
- a software force strobe;
- a single-cycle external event pulse.

Each source has its own enable bit for each group. A fault that is seen is held in a per-group source flag. The flag stays set until software clears it with a clear strobe and a source mask. An interrupt request follows any held comparator flag while interrupts are enabled.

Source bit order in all five-bit vectors: [0] detection, [1] comparator, [2] oscillation stop, [3] software force, [4] external event.

Top module: `eod_ctrl`

## Requirements
- R1: After reset, both flag vectors are 0, every output enable is 1 and `irq` is 0.
- R2: Pair p is pins 2p and 2p+1 of `pwm_lvl`. `pol[p]`=1 means the active level is high; 0 means it is low. When both pins of any pair sit at the active level on a clock edge, source bit 1 is set in each group whose enable bit 1 is set. A pair whose pins both sit at the inactive level sets nothing.
- R3: `osc_stop` high on an edge sets source bit 2 in each group that enables it.
- R4: `sw_force` high on an edge sets source bit 3 in each group that enables it.
- R5: A one-cycle `evt_pulse` sets source bit 4 in each group that enables it.
- R6: Any bit of `det_flag` high on an edge sets source bit 0 in each group that enables it.
- R7: A source whose enable bit is 0 for a group never sets that group's flag, and that group's output enables stay 1.
- R8: A set flag holds after its source goes away. A `clr_wr` strobe clears only the flags selected in `clr_mask`. A source that is still active on the clearing edge keeps its flag set.
- R9: `irq` is 1 exactly when `irq_en` is 1 and source bit 1 is held in either group. It updates on the same edge as the flags.
- R10: All enables of a group equal the NOR of that group's flags. They fall on the same edge that sets the first flag, which is one clock after the fault becomes visible at the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_flag | input | NDET | Input-level detection flags |
| pwm_lvl | input | 2*NPAIR | Complementary pin levels, pair p on bits 2p/2p+1 |
| pol | input | NPAIR | Active level per pair, 1 = high |
| osc_stop | input | 1 | Oscillation-stop indication |
| sw_force | input | 1 | Software force strobe |
| evt_pulse | input | 1 | External event pulse |
| en_cp | input | NSRC | Source enables for the complementary group |
| en_solo | input | NSRC | Source enables for the single-channel group |
| irq_en | input | 1 | Interrupt enable for comparator faults |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | NSRC | Sources cleared by the strobe |
| oe_cp | output | 2*NPAIR | Complementary group output enables |
| oe_solo | output | NSOLO | Single-channel group output enables |
| src_flags_cp | output | NSRC | Held source flags, complementary group |
| src_flags_solo | output | NSRC | Held source flags, single-channel group |
| irq | output | 1 | Comparator interrupt request |

## Verification
Every result is due one clock after its stimulus. This holds for a flag set, an enable drop, an `irq` change and a clear: each is a single register stage fed by the sampled inputs. The bench drives inputs on the falling edge, which places their sampling at the next rising edge, and reads outputs at the following falling edge. Each vector is read three times: once right after the stimulus edge, once after an idle edge to confirm the hold, and once after the clear edge.

// File: rtl/eod_pkg.sv
package eod_pkg;
    localparam int NSRC    = 5;
    localparam int SRC_DET = 0;
    localparam int SRC_CMP = 1;
    localparam int SRC_OSC = 2;
    localparam int SRC_SW  = 3;
    localparam int SRC_EVT = 4;

    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/eod_short_cmp.sv
module eod_short_cmp #(
    parameter int NPAIR = 3
) (
    input  logic [2*NPAIR-1:0] pwm_lvl,
    input  logic [NPAIR-1:0]   pol,
    output logic               short_any
);
    logic [NPAIR-1:0] pair_short;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        always_comb begin
            pair_short[p] = (pwm_lvl[2*p] == pol[p]) && (pwm_lvl[2*p+1] == pol[p]);
        end
    end

    always_comb begin
        short_any = |pair_short;
    end
endmodule

// File: rtl/eod_grp_latch.sv
module eod_grp_latch
    import eod_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t src_act,
    input  src_vec_t src_en,
    input  logic     clr_wr,
    input  src_vec_t clr_mask,
    output src_vec_t flags_q,
    output src_vec_t flags_d
);
    typedef struct packed {
        src_vec_t flags;
    } grp_state_t;

    grp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_wr) begin
            st_d.flags = st_q.flags & ~clr_mask;
        end
        st_d.flags = st_d.flags | (src_act & src_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign flags_d = st_d.flags;
endmodule

// File: rtl/eod_ctrl.sv
module eod_ctrl
    import eod_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int NSOLO = 3,
    parameter int NDET  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NDET-1:0]    det_flag,
    input  logic [2*NPAIR-1:0] pwm_lvl,
    input  logic [NPAIR-1:0]   pol,
    input  logic               osc_stop,
    input  logic               sw_force,
    input  logic               evt_pulse,
    input  logic [NSRC-1:0]    en_cp,
    input  logic [NSRC-1:0]    en_solo,
    input  logic               irq_en,
    input  logic               clr_wr,
    input  logic [NSRC-1:0]    clr_mask,
    output logic [2*NPAIR-1:0] oe_cp,
    output logic [NSOLO-1:0]   oe_solo,
    output logic [NSRC-1:0]    src_flags_cp,
    output logic [NSRC-1:0]    src_flags_solo,
    output logic               irq
);
    localparam int NCP = 2 * NPAIR;
    localparam int NGRP = 2;

    typedef struct packed {
        logic [NCP-1:0]   oe_cp;
        logic [NSOLO-1:0] oe_solo;
        logic             irq;
    } top_state_t;

    logic     short_any;
    src_vec_t src_act;
    src_vec_t grp_en    [NGRP];
    src_vec_t grp_flags [NGRP];
    src_vec_t grp_next  [NGRP];
    top_state_t st_d, st_q;

    eod_short_cmp #(.NPAIR(NPAIR)) u_cmp (
        .pwm_lvl   (pwm_lvl),
        .pol       (pol),
        .short_any (short_any)
    );

    always_comb begin
        src_act          = '0;
        src_act[SRC_DET] = |det_flag;
        src_act[SRC_CMP] = short_any;
        src_act[SRC_OSC] = osc_stop;
        src_act[SRC_SW]  = sw_force;
        src_act[SRC_EVT] = evt_pulse;
    end

    assign grp_en[0] = en_cp;
    assign grp_en[1] = en_solo;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        eod_grp_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_act  (src_act),
            .src_en   (grp_en[g]),
            .clr_wr   (clr_wr),
            .clr_mask (clr_mask),
            .flags_q  (grp_flags[g]),
            .flags_d  (grp_next[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.oe_cp   = {NCP{~|grp_next[0]}};
        st_d.oe_solo = {NSOLO{~|grp_next[1]}};
        st_d.irq     = irq_en && (grp_next[0][SRC_CMP] || grp_next[1][SRC_CMP]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.oe_cp   <= '1;
            st_q.oe_solo <= '1;
            st_q.irq     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_cp          = st_q.oe_cp;
    assign oe_solo        = st_q.oe_solo;
    assign irq            = st_q.irq;
    assign src_flags_cp   = grp_flags[0];
    assign src_flags_solo = grp_flags[1];
endmodule

// File: rtl/eod_ctrl_chk.sv
module eod_ctrl_chk
    import eod_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int NSOLO = 3,
    parameter int NDET  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NDET-1:0]    det_flag,
    input logic               osc_stop,
    input logic               sw_force,
    input logic               evt_pulse,
    input logic [NSRC-1:0]    en_cp,
    input logic [NSRC-1:0]    en_solo,
    input logic               irq_en,
    input logic               clr_wr,
    input logic [NSRC-1:0]    clr_mask,
    input logic [2*NPAIR-1:0] oe_cp,
    input logic [NSOLO-1:0]   oe_solo,
    input logic [NSRC-1:0]    src_flags_cp,
    input logic [NSRC-1:0]    src_flags_solo,
    input logic               irq
);
    assert_oe_cp_follows_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_cp == {(2*NPAIR){~|src_flags_cp}});

    assert_oe_solo_follows_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_solo == {NSOLO{~|src_flags_solo}});

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && (src_flags_cp[SRC_CMP] || src_flags_solo[SRC_CMP])));

    assert_osc_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flags_cp[SRC_OSC]) |-> $past(osc_stop));

    assert_force_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flags_solo[SRC_SW]) |-> $past(sw_force));

    assert_evt_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flags_cp[SRC_EVT]) |-> $past(evt_pulse));

    assert_det_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_flags_solo[SRC_DET]) |-> $past(|det_flag));

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assert_cp_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_flags_cp[k]) |-> $past(en_cp[k]));

        assert_solo_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_flags_solo[k]) |-> $past(en_solo[k]));

        assert_cp_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(src_flags_cp[k]) |-> $past(clr_wr && clr_mask[k]));

        assert_solo_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(src_flags_solo[k]) |-> $past(clr_wr && clr_mask[k]));
    end
endmodule

bind eod_ctrl eod_ctrl_chk #(.NPAIR(NPAIR), .NSOLO(NSOLO), .NDET(NDET)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .det_flag       (det_flag),
    .osc_stop       (osc_stop),
    .sw_force       (sw_force),
    .evt_pulse      (evt_pulse),
    .en_cp          (en_cp),
    .en_solo        (en_solo),
    .irq_en         (irq_en),
    .clr_wr         (clr_wr),
    .clr_mask       (clr_mask),
    .oe_cp          (oe_cp),
    .oe_solo        (oe_solo),
    .src_flags_cp   (src_flags_cp),
    .src_flags_solo (src_flags_solo),
    .irq            (irq)
);

// File: tb/eod_ctrl_tb_top.sv
`timescale 1ns/1ps
module eod_ctrl_tb_top;
    localparam int NPAIR = 3;
    localparam int NSOLO = 3;
    localparam int NDET  = 4;
    localparam int NS    = 5;
    localparam int VW    = 38;
    localparam int NVEC  = 9;

    // {det4, lvl6, pol3, osc, frc, evt, en_cp5, en_solo5, irq_en, exp_cp5, exp_solo5, exp_irq}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'b0000, 6'b010101, 3'b111, 3'b000, 5'b11111, 5'b11111, 1'b1, 5'b00000, 5'b00000, 1'b0},
        {4'b0001, 6'b010101, 3'b111, 3'b000, 5'b11111, 5'b11111, 1'b0, 5'b00001, 5'b00001, 1'b0},
        {4'b0000, 6'b011101, 3'b111, 3'b000, 5'b11111, 5'b11111, 1'b1, 5'b00010, 5'b00010, 1'b1},
        {4'b0000, 6'b010100, 3'b110, 3'b000, 5'b11111, 5'b11111, 1'b0, 5'b00010, 5'b00010, 1'b0},
        {4'b0000, 6'b000000, 3'b111, 3'b000, 5'b11111, 5'b11111, 1'b1, 5'b00000, 5'b00000, 1'b0},
        {4'b0000, 6'b010101, 3'b111, 3'b100, 5'b11111, 5'b11011, 1'b0, 5'b00100, 5'b00000, 1'b0},
        {4'b0000, 6'b010101, 3'b111, 3'b010, 5'b10111, 5'b11111, 1'b0, 5'b00000, 5'b01000, 1'b0},
        {4'b0000, 6'b010101, 3'b111, 3'b001, 5'b11111, 5'b11111, 1'b0, 5'b10000, 5'b10000, 1'b0},
        {4'b1000, 6'b110101, 3'b111, 3'b111, 5'b00000, 5'b11111, 1'b1, 5'b00000, 5'b11111, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NDET-1:0]    det_flag = '0;
    logic [2*NPAIR-1:0] pwm_lvl = 6'b010101;
    logic [NPAIR-1:0]   pol = 3'b111;
    logic osc_stop = 1'b0, sw_force = 1'b0, evt_pulse = 1'b0;
    logic [NS-1:0] en_cp = '1, en_solo = '1, clr_mask = '0;
    logic irq_en = 1'b0, clr_wr = 1'b0;
    logic [2*NPAIR-1:0] oe_cp;
    logic [NSOLO-1:0]   oe_solo;
    logic [NS-1:0]      src_flags_cp, src_flags_solo;
    logic               irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eod_ctrl #(.NPAIR(NPAIR), .NSOLO(NSOLO), .NDET(NDET)) dut_i (
        .clk(clk), .rst_n(rst_n), .det_flag(det_flag), .pwm_lvl(pwm_lvl), .pol(pol),
        .osc_stop(osc_stop), .sw_force(sw_force), .evt_pulse(evt_pulse),
        .en_cp(en_cp), .en_solo(en_solo), .irq_en(irq_en), .clr_wr(clr_wr),
        .clr_mask(clr_mask), .oe_cp(oe_cp), .oe_solo(oe_solo),
        .src_flags_cp(src_flags_cp), .src_flags_solo(src_flags_solo), .irq(irq)
    );

    task automatic check(input string req, input logic [NS-1:0] ecp, input logic [NS-1:0] eso,
                         input logic eirq);
        logic [2*NPAIR-1:0] eoc;
        logic [NSOLO-1:0]   eos;
        eoc = {(2*NPAIR){~|ecp}};
        eos = {NSOLO{~|eso}};
        n_chk++;
        if (src_flags_cp !== ecp || src_flags_solo !== eso || irq !== eirq ||
            oe_cp !== eoc || oe_solo !== eos) begin
            n_fail++;
            $display("FAIL %s: cp=%b solo=%b irq=%b oe_cp=%b oe_solo=%b exp cp=%b solo=%b irq=%b oe_cp=%b oe_solo=%b",
                     req, src_flags_cp, src_flags_solo, irq, oe_cp, oe_solo, ecp, eso, eirq, eoc, eos);
        end
    endtask

    task automatic idle_src();
        det_flag = '0; pwm_lvl = 6'b010101; pol = 3'b111;
        osc_stop = 1'b0; sw_force = 1'b0; evt_pulse = 1'b0;
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        idle_src();
        clr_wr = 1'b1; clr_mask = '1;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 5'b0, 5'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 5'b0, 5'b0, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            {det_flag, pwm_lvl, pol, osc_stop, sw_force, evt_pulse, en_cp, en_solo, irq_en} = v[VW-1:11];
            @(negedge clk);
            check($sformatf("R2-R7/R9/R10 vec%0d", i), v[10:6], v[5:1], v[0]);
            idle_src();
            @(negedge clk);
            check($sformatf("R8 hold vec%0d", i), v[10:6], v[5:1], v[0]);
            clr_wr = 1'b1; clr_mask = '1;
            @(negedge clk);
            clr_wr = 1'b0; clr_mask = '0;
            check($sformatf("R8 clear vec%0d", i), 5'b0, 5'b0, 1'b0);
        end

        en_cp = '1; en_solo = '1; irq_en = 1'b0;
        osc_stop = 1'b1;
        @(negedge clk);
        clr_wr = 1'b1; clr_mask = '1;
        @(negedge clk);
        check("R8 clear while active keeps flag", 5'b00100, 5'b00100, 1'b0);
        clear_all();
        check("R8 cleared after source gone", 5'b0, 5'b0, 1'b0);

        sw_force = 1'b1; evt_pulse = 1'b1;
        @(negedge clk);
        idle_src();
        clr_wr = 1'b1; clr_mask = 5'b01000;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = '0;
        check("R8 partial mask clears only force", 5'b10000, 5'b10000, 1'b0);
        clear_all();

        en_cp = 5'b01111; en_solo = 5'b01111;
        evt_pulse = 1'b1;
        @(negedge clk);
        evt_pulse = 1'b0;
        en_cp = '1; en_solo = '1;
        @(negedge clk);
        check("R7 disabled pulse leaves no trace", 5'b0, 5'b0, 1'b0);

        irq_en = 1'b0;
        pwm_lvl = 6'b110101;
        @(negedge clk);
        pwm_lvl = 6'b010101;
        check("R9 comparator held, irq masked", 5'b00010, 5'b00010, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq follows late enable", 5'b00010, 5'b00010, 1'b1);
        clear_all();
        check("R9 irq drops on clear", 5'b0, 5'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule